// File: doc/BRIEF.md
# Parallel Display Bus Write Controller

This block writes to a display panel over a parallel bus. It supports two bus styles with one sequencing engine. In the separate-strobe style, a low-active write strobe is pulsed once for each word, and the panel captures the word on the strobe's rising edge. In the enable-clocked style, the read/write line is held at its write level for the whole transfer, and a high-active enable is pulsed once for each word. The style, the bus width (8, 9 or 16 bits) and three per-word phase lengths are configuration inputs, sampled when a request is accepted.

A request carries an optional command byte and a count of data words. The data words come in on a valid/ready stream. Chip-select stays active over the command phase and the data phase. The data/command line is low for the command byte and high for the data words. A separate request produces a panel reset pulse whose length is programmable. A request with an unsupported style or width is refused. A refused request raises a one-cycle error flag and leaves the bus untouched.

States: `ST_IDLE` (bus at rest, accepts requests), `ST_RSTP` (panel reset low), `ST_CSON` (chip-select opened, data/command set), `ST_FETCH` (waits for a stream word), `ST_SETUP` (strobe active, previous word still on the bus), `ST_ACT` (strobe active, new word on the bus), `ST_HOLD` (strobe released, word held). Transitions:
- IDLE→CSON on an accepted request.
- IDLE→RSTP on a reset request.
- RSTP→IDLE when the pulse ends.
- CSON→SETUP when a command is present.
- CSON→FETCH when there is no command and the count is nonzero.
- CSON→IDLE when there is no command and the count is zero.
- FETCH→SETUP on a handshake.
- SETUP→ACT and ACT→HOLD when each phase timer expires.
- HOLD→FETCH when words remain.
- HOLD→IDLE after the last word.

Top module: `pdb_write_ctrl`

## Requirements
- R1: At rest, the outputs are: `bus_cs_n`=1, `bus_wr_n`=1, `bus_rd_n`=1, `bus_en`=0, `bus_dc`=0, `bus_data`=0, `disp_rst_n`=1, `busy`=0. `bus_rd_n` is never driven low.
- R2: `cfg_mode` code 0 selects separate-strobe and code 1 selects enable-clocked. Codes 2 and 3, or a `cfg_width` other than 8, 9 or 16, refuse the request. On a refusal, `err` is high for exactly the next cycle, `busy` stays low and chip-select stays inactive.
- R3: In separate-strobe mode, each word drives `bus_wr_n` low for setup+active cycles. The bus keeps the previous word (0 for the first word of a transfer) during the setup cycles, then shows the new word. The word stays on the bus after `bus_wr_n` returns high. `bus_en` stays 0.
- R4: In enable-clocked mode, `bus_wr_n` is 0 for the whole chip-select window and `bus_en` is high for setup+active cycles per word. The bus contents follow the same order as in R3.
- R5: The setup, active and hold phases last `cfg_setup`, `cfg_active` and `cfg_hold` cycles. A value of 0 counts as 1. Between two strobes of one transfer there are at least hold+1 inactive cycles.
- R6: Chip-select goes low in the cycle after acceptance. Strobes occur only while it is low. It returns high exactly hold cycles after the last strobe ends.
- R7: With `req_has_cmd`=1, the first word sent is `req_cmd` zero-extended with `bus_dc`=0. All following words are sent with `bus_dc`=1.
- R8: With `req_has_cmd`=0, only the `req_len` data words are sent, all with `bus_dc`=1. With `req_len`=0 as well, chip-select opens and closes with no strobe.
- R9: Bus bits at or above the configured width are driven 0.
- R10: `din_ready` is high only while waiting for the next word. A word is taken when `din_valid` and `din_ready` are both high. Stalls on `din_valid` delay the transfer without losing or repeating a word.
- R11: `busy` equals the chip-select window during a transfer, rising in the cycle after acceptance. Requests made while busy are ignored.
- R12: A reset request drives `disp_rst_n` low for `rst_cycles` cycles (0 counts as 1), with `busy` high and chip-select inactive throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Bus style: 0 separate-strobe, 1 enable-clocked |
| cfg_width | input | 5 | Bus width in bits: 8, 9 or 16 |
| cfg_setup | input | TW | Setup phase length in cycles |
| cfg_active | input | TW | Active phase length in cycles |
| cfg_hold | input | TW | Hold phase length in cycles |
| req_valid | input | 1 | Transfer request strobe |
| req_has_cmd | input | 1 | Request includes a command byte |
| req_cmd | input | 8 | Command byte |
| req_len | input | LW | Number of data words |
| din | input | DW | Stream data word |
| din_valid | input | 1 | Stream word valid |
| din_ready | output | 1 | Stream word taken |
| rst_req | input | 1 | Panel reset request |
| rst_cycles | input | RW | Panel reset pulse length |
| busy | output | 1 | Engine occupied |
| err | output | 1 | Request refused (one-cycle pulse) |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_dc | output | 1 | Data/command select (1 = data) |
| bus_wr_n | output | 1 | Write strobe, or read/write line in enable-clocked mode |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_en | output | 1 | Enable clock for enable-clocked mode |
| bus_data | output | DW | Parallel data bus |
| disp_rst_n | output | 1 | Panel reset, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, 4-bit phase fields, 8-bit word counts and 8-bit reset lengths. With these settings, all three widths, a zero phase field that counts as one, and multi-cycle phases can all be reached. The bench sweeps both bus styles, all three widths, transfers with and without a command, word counts of 0, 1 and 4, and three phase-timing sets. One of the timing sets stalls the stream. Separate runs cover the panel reset, refused configurations and a request made while busy.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
    localparam logic [1:0] MODE_SEP = 2'd0;
    localparam logic [1:0] MODE_ENA = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RSTP, ST_CSON, ST_FETCH, ST_SETUP, ST_ACT, ST_HOLD
    } pdb_state_t;

    function automatic logic width_ok(input logic [4:0] w);
        return (w == 5'd8) || (w == 5'd9) || (w == 5'd16);
    endfunction
endpackage

// File: rtl/pdb_phase_timer.sv
module pdb_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // a zero length behaves like one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (len == '0) ? '0 : len - CW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pdb_width_mask.sv
module pdb_width_mask #(
    parameter int DW = 16
) (
    input  logic [4:0]    width,
    output logic [DW-1:0] mask
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign mask[i] = (width > 5'(i));
    end
endmodule

// File: rtl/pdb_write_ctrl.sv
module pdb_write_ctrl
    import pdb_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 4,
    parameter int LW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic [4:0]    cfg_width,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_active,
    input  logic [TW-1:0] cfg_hold,
    input  logic          req_valid,
    input  logic          req_has_cmd,
    input  logic [7:0]    req_cmd,
    input  logic [LW-1:0] req_len,
    input  logic [DW-1:0] din,
    input  logic          din_valid,
    output logic          din_ready,
    input  logic          rst_req,
    input  logic [RW-1:0] rst_cycles,
    output logic          busy,
    output logic          err,
    output logic          bus_cs_n,
    output logic          bus_dc,
    output logic          bus_wr_n,
    output logic          bus_rd_n,
    output logic          bus_en,
    output logic [DW-1:0] bus_data,
    output logic          disp_rst_n
);
    localparam int CW = (TW > RW) ? TW : RW;

    pdb_state_t    state_q, state_d;
    logic [1:0]    mode_q;
    logic [4:0]    width_q;
    logic [TW-1:0] tsu_q, tact_q, thold_q;
    logic          has_cmd_q;
    logic [LW-1:0] rem_q;
    logic [DW-1:0] word_q, data_q, mask;
    logic          dc_q, err_q;
    logic          t_load, t_done;
    logic [CW-1:0] t_len;
    logic          cfg_ok, in_txn, strobe;

    assign cfg_ok = ((cfg_mode == MODE_SEP) || (cfg_mode == MODE_ENA)) && width_ok(cfg_width);

    pdb_width_mask #(.DW(DW)) u_mask (.width(width_q), .mask(mask));

    pdb_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .done(t_done)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = cfg_ok ? ST_CSON : ST_IDLE;
                else if (rst_req) state_d = ST_RSTP;
            end
            ST_RSTP:  if (t_done) state_d = ST_IDLE;
            ST_CSON: begin
                if (has_cmd_q) state_d = ST_SETUP;
                else if (rem_q != '0) state_d = ST_FETCH;
                else state_d = ST_IDLE;
            end
            ST_FETCH: if (din_valid) state_d = ST_SETUP;
            ST_SETUP: if (t_done) state_d = ST_ACT;
            ST_ACT:   if (t_done) state_d = ST_HOLD;
            ST_HOLD:  if (t_done) state_d = (rem_q != '0) ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // phase timer load on entry to a timed state
    always_comb begin
        t_len = '0;
        unique case (state_d)
            ST_SETUP: t_len = CW'(tsu_q);
            ST_ACT:   t_len = CW'(tact_q);
            ST_HOLD:  t_len = CW'(thold_q);
            ST_RSTP:  t_len = CW'(rst_cycles);
            default:  t_len = '0;
        endcase
        t_load = (state_d != state_q) &&
                 (state_d == ST_SETUP || state_d == ST_ACT ||
                  state_d == ST_HOLD  || state_d == ST_RSTP);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context and bus registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SEP; width_q <= 5'd8;
            tsu_q <= '0; tact_q <= '0; thold_q <= '0;
            has_cmd_q <= 1'b0; rem_q <= '0; word_q <= '0;
            data_q <= '0; dc_q <= 1'b0; err_q <= 1'b0;
        end else begin
            err_q <= (state_q == ST_IDLE) && req_valid && !cfg_ok;
            if (state_q == ST_IDLE && req_valid && cfg_ok) begin
                mode_q    <= cfg_mode;
                width_q   <= cfg_width;
                tsu_q     <= cfg_setup;
                tact_q    <= cfg_active;
                thold_q   <= cfg_hold;
                has_cmd_q <= req_has_cmd;
                rem_q     <= req_len;
                word_q    <= {{(DW-8){1'b0}}, req_cmd};
                dc_q      <= !req_has_cmd;
            end
            if (state_q == ST_FETCH && din_valid) begin
                word_q <= din;
                rem_q  <= rem_q - LW'(1);
            end
            if (state_d == ST_FETCH) dc_q <= 1'b1;
            if (state_q == ST_SETUP && state_d == ST_ACT) data_q <= word_q & mask;
            if (state_d == ST_IDLE) begin
                dc_q   <= 1'b0;
                data_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        in_txn     = (state_q == ST_CSON) || (state_q == ST_FETCH) || (state_q == ST_SETUP) ||
                     (state_q == ST_ACT)  || (state_q == ST_HOLD);
        strobe     = (state_q == ST_SETUP) || (state_q == ST_ACT);
        busy       = (state_q != ST_IDLE);
        err        = err_q;
        bus_cs_n   = !in_txn;
        bus_dc     = dc_q;
        bus_rd_n   = 1'b1;
        bus_data   = data_q;
        din_ready  = (state_q == ST_FETCH);
        disp_rst_n = (state_q != ST_RSTP);
        if (mode_q == MODE_SEP) begin
            bus_wr_n = !strobe;
            bus_en   = 1'b0;
        end else begin
            bus_wr_n = !in_txn;
            bus_en   = strobe;
        end
    end
endmodule

// File: rtl/pdb_write_ctrl_chk.sv
module pdb_write_ctrl_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          err,
    input logic          bus_cs_n,
    input logic          bus_dc,
    input logic          bus_wr_n,
    input logic          bus_rd_n,
    input logic          bus_en,
    input logic [DW-1:0] bus_data,
    input logic          disp_rst_n,
    input logic          din_ready
);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_wr_n && !bus_en && !bus_dc && bus_data == '0 && disp_rst_n));

    // R1
    rd_high_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_rd_n);

    // R2
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && bus_cs_n));

    // R6
    strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en || !bus_wr_n) |-> !bus_cs_n);

    // R6
    cs_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> !bus_en);

    // R7
    dc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_dc) |-> bus_cs_n);

    // R10
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> (busy && !bus_cs_n && !bus_en));

    // R12
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> (busy && bus_cs_n));
endmodule

bind pdb_write_ctrl pdb_write_ctrl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .bus_cs_n(bus_cs_n),
    .bus_dc(bus_dc), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_en(bus_en),
    .bus_data(bus_data), .disp_rst_n(disp_rst_n), .din_ready(din_ready)
);

// File: tb/sim_pdb_write_ctrl.sv
`timescale 1ns/1ps
module sim_pdb_write_ctrl;
    localparam int DW = 16, TW = 4, LW = 8, RW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [4:0] cfg_width = 5'd8;
    logic [TW-1:0] cfg_setup = '0, cfg_active = '0, cfg_hold = '0;
    logic req_valid = 1'b0, req_has_cmd = 1'b0;
    logic [7:0] req_cmd = '0;
    logic [LW-1:0] req_len = '0;
    logic [DW-1:0] din = '0;
    logic din_valid = 1'b0, din_ready;
    logic rst_req = 1'b0;
    logic [RW-1:0] rst_cycles = '0;
    logic busy, err, bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_en, disp_rst_n;
    logic [DW-1:0] bus_data;

    pdb_write_ctrl #(.DW(DW), .TW(TW), .LW(LW), .RW(RW)) u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int s, input int k);
        return 16'(32'h5A3C + s * 32'h0101 + k * 32'h2D17);
    endfunction

    // stream source
    int seed = 0, acc = 0, stc = 0;
    bit stall_en = 0, took = 0;
    always @(negedge clk) begin
        if (took) acc++;
        din = pat(seed, acc);
        stc++;
        din_valid = !stall_en || (stc % 3 != 0);
        took = din_valid && din_ready;
    end

    // bus monitor
    int n = 0, run = 0, gap = 0, tail = 0, bad_frame = 0, bad_busy = 0;
    int gw[16], gd[16], gr[16], gg[16], gs[16];
    bit cur_mode = 0, act_prev = 0, rst_test = 0;
    always @(negedge clk) begin
        bit act;
        if (rst_n) begin
            act = (cur_mode == 0) ? !bus_wr_n : bus_en;
            if (act) begin
                if (!act_prev && n < 16) begin gg[n] = gap; gs[n] = int'(bus_data); end
                run++;
            end else if (act_prev) begin
                if (n < 16) begin gw[n] = int'(bus_data); gd[n] = int'(bus_dc); gr[n] = run; end
                n++; run = 0; gap = 0; tail = 0;
            end
            if (!act) gap++;
            if (!act && !bus_cs_n) tail++;
            if (act && bus_cs_n) bad_frame++;
            if (!bus_rd_n) bad_frame++;
            if (cur_mode == 0 && bus_en) bad_frame++;
            if (cur_mode == 1 && !bus_cs_n && bus_wr_n) bad_frame++;
            if (!rst_test && (busy != !bus_cs_n)) bad_busy++;
            act_prev = act;
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_txn(input int mode, input int width, input int s, input int a, input int h,
                           input bit hc, input int cmd, input int len, input bit stall, input bit intr);
        int exp_n, e_w, e_d, prev, msk;
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_width = 5'(width);
        cfg_setup = TW'(s); cfg_active = TW'(a); cfg_hold = TW'(h);
        req_has_cmd = hc; req_cmd = 8'(cmd); req_len = LW'(len);
        cur_mode = mode[0]; stall_en = stall; seed = mode * 7 + width + len;
        n = 0; bad_frame = 0; bad_busy = 0; acc = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && bus_cs_n == 1'b0, "R11 busy/cs after accept", int'(busy), 1);
        if (intr) begin
            repeat (3) @(negedge clk);
            req_has_cmd = 1'b0; req_len = LW'(7); req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
        repeat (2) @(negedge clk);
        exp_n = int'(hc) + len;
        msk = (1 << width) - 1;
        chk(n == exp_n, hc ? "R7 word count" : "R8 word count", n, exp_n);
        prev = 0;
        for (int k = 0; k < exp_n && k < n; k++) begin
            if (hc && k == 0) begin e_w = cmd & msk; e_d = 0; end
            else begin e_w = int'(pat(seed, k - int'(hc))) & msk; e_d = 1; end
            chk(gw[k] == e_w, "R9 word value", gw[k], e_w);
            chk(gd[k] == e_d, hc ? "R7 dc level" : "R8 dc level", gd[k], e_d);
            chk(gr[k] == eff(s) + eff(a), "R5 strobe length", gr[k], eff(s) + eff(a));
            chk(gs[k] == prev, mode == 0 ? "R3 data after strobe" : "R4 data after enable", gs[k], prev);
            if (k > 0) chk(gg[k] >= eff(h) + 1, "R5 hold gap", gg[k], eff(h) + 1);
            prev = e_w;
        end
        if (exp_n > 0) chk(tail == eff(h), "R6 cs tail", tail, eff(h));
        chk(bad_frame == 0, mode == 0 ? "R3 strobe framing" : "R4 enable framing", bad_frame, 0);
        chk(bad_busy == 0, "R11 busy matches window", bad_busy, 0);
        chk(acc == len, "R10 stream words taken", acc, len);
        if (intr) begin
            int opened = 0;
            for (int g = 0; g < 6; g++) begin
                @(negedge clk);
                if (!bus_cs_n) opened++;
            end
            chk(opened == 0, "R11 request while busy ignored", opened, 0);
        end
    endtask

    task automatic refuse(input int mode, input int width);
        int opened = 0, e1, e2;
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_width = 5'(width); req_len = LW'(2); req_has_cmd = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e1 = int'(err);
        if (busy || !bus_cs_n) opened++;
        @(negedge clk);
        e2 = int'(err);
        for (int g = 0; g < 6; g++) begin
            if (busy || !bus_cs_n) opened++;
            @(negedge clk);
        end
        chk(e1 == 1 && e2 == 0, "R2 error pulse", e1 * 2 + e2, 2);
        chk(opened == 0, "R2 no bus activity", opened, 0);
    endtask

    task automatic panel_reset(input int len);
        int low = 0, bsy = 0;
        @(negedge clk);
        rst_test = 1; rst_cycles = RW'(len); rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        for (int g = 0; g < 600 && !disp_rst_n; g++) begin
            low++;
            if (busy && bus_cs_n) bsy++;
            @(negedge clk);
        end
        chk(low == eff(len), "R12 reset pulse length", low, eff(len));
        chk(bsy == eff(len), "R12 busy during reset", bsy, eff(len));
        @(negedge clk);
        rst_test = 0;
    endtask

    initial begin
        repeat (600000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int ts_s[3] = '{1, 2, 0};
        int ts_a[3] = '{1, 3, 2};
        int ts_h[3] = '{1, 1, 3};
        int widths[3] = '{8, 9, 16};
        int lens[3] = '{0, 1, 4};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_en && !bus_dc && bus_data == '0 &&
            disp_rst_n && !busy && !err, "R1 rest levels",
            {bus_cs_n, bus_wr_n, bus_rd_n, bus_en, bus_dc, disp_rst_n, busy}, 7'b1110010);
        for (int t = 0; t < 3; t++)
            for (int m = 0; m < 2; m++)
                for (int w = 0; w < 3; w++)
                    for (int c = 0; c < 2; c++)
                        for (int l = 0; l < 3; l++)
                            run_txn(m, widths[w], ts_s[t], ts_a[t], ts_h[t], c[0],
                                    8'hC5 ^ (t * 16 + w), lens[l], t == 1, 1'b0);
        run_txn(0, 16, 1, 1, 1, 1'b1, 8'h2A, 3, 1'b0, 1'b1);
        run_txn(1, 9, 2, 1, 2, 1'b0, 8'h00, 2, 1'b1, 1'b1);
        refuse(2, 8);
        refuse(3, 16);
        refuse(0, 12);
        refuse(1, 7);
        panel_reset(5);
        panel_reset(0);
        panel_reset(1);
        @(negedge clk);
        chk(bus_cs_n && disp_rst_n && !busy && bus_data == '0, "R1 rest after runs",
            int'(busy), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule